// File: doc/BRIEF.md
# Hidden DAC Register Unlock Sequencer

This block guards one hidden configuration register that shares an access port with the ordinary pixel-mask register of a VGA-style RAMDAC. Software opens the hidden register by reading the shared port several times in a row. The counter advances on each read and is cleared by any write. While the port is locked, every read returns all ones. The read that brings the count one past the unlock threshold returns the hidden value and clears the counter. A write reaches the hidden register only if exactly the threshold number of reads has come before it since the last clear.

The port has a read strobe, a write strobe, write data and registered read data. Read data appears on the clock after the read strobe and then holds until the next read. The hidden value is also driven on its own output, so downstream logic can use it without going through the port.

The read strobe and the write strobe must never be high in the same cycle. If they are, the design treats the cycle as a write only.

Top module: `hdac_unlock_seq`

## Requirements
- R1: After a synchronous reset, `hidden_q` is 0x00, `rdata` is 0xFF and the read counter is zero.
- R2: A read issued while the counter is below four returns 0xFF on `rdata` one clock after the read strobe and advances the counter by one.
- R3: A read issued while the counter equals four returns the current hidden value on `rdata` one clock after the strobe and resets the counter to zero. Idle cycles between reads do not disturb the count, so every fifth read after a clear unlocks.
- R4: A write issued while the counter equals four stores `wdata` into the hidden register, and `hidden_q` shows the new value one clock after the strobe.
- R5: A write issued while the counter is not four leaves `hidden_q` unchanged. This covers a count of zero right after an unlocking read.
- R6: Every write clears the counter to zero, whether or not it stores data. The next unlock therefore needs four fresh reads.
- R7: `rdata` changes only on a read. Idle cycles and writes leave it holding its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| hidden_q | output | DATA_W | Current hidden register value |

## Verification
The bench targets the off-by-one edges of the count:
- **Arming point.** Writes after three and after five reads must not store. A design that arms one read early or late would store on one of them.
- **Clear on every write.** Two reads, a write, then two more reads must not arm the block. A design that clears the counter only on storing writes would arm after the fourth read and accept the second write.
- **Wrap after unlock.** Repeating the unlock after it has been used catches a counter that does not return to zero.
- **Read data held.** Checking `rdata` across idle cycles and writes catches a read path that reloads outside real reads.

// File: rtl/hdac_pkg.sv
package hdac_pkg;

  // Kind of access seen on the shared port in one cycle.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  // Counter width able to hold the unlock threshold itself.
  function automatic int cnt_width(input int threshold);
    return (threshold < 1) ? 1 : $clog2(threshold + 1);
  endfunction

endpackage

// File: rtl/hdac_decode.sv
module hdac_decode
  import hdac_pkg::*;
(
  input  logic rd_en,
  input  logic wr_en,
  output acc_e acc
);

  // A write wins if both strobes are raised (illegal usage).
  always_comb begin
    if (wr_en)      acc = ACC_WR;
    else if (rd_en) acc = ACC_RD;
    else            acc = ACC_NONE;
  end

endmodule

// File: rtl/hdac_unlock_cnt.sv
module hdac_unlock_cnt
  import hdac_pkg::*;
#(
  parameter int UNLOCK_READS = 4,
  localparam int CNT_W = cnt_width(UNLOCK_READS)
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_e             acc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_READS);

  assign armed = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (acc)
        ACC_WR:  cnt_q <= '0;
        ACC_RD:  cnt_q <= armed ? '0 : cnt_q + 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/hdac_hidden_reg.sv
module hdac_hidden_reg
  import hdac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              acc,
  input  logic              armed,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= RESET_VAL;
    end else if (acc == ACC_WR && armed) begin
      value_q <= wdata;
    end
  end

endmodule

// File: rtl/hdac_rd_path.sv
module hdac_rd_path
  import hdac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              acc,
  input  logic              armed,
  input  logic [DATA_W-1:0] hidden,
  output logic [DATA_W-1:0] rdata_q
);

  localparam logic [DATA_W-1:0] LOCKED_VAL = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= LOCKED_VAL;
    end else if (acc == ACC_RD) begin
      rdata_q <= armed ? hidden : LOCKED_VAL;
    end
  end

endmodule

// File: rtl/hdac_unlock_seq.sv
module hdac_unlock_seq
  import hdac_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int UNLOCK_READS = 4,
  localparam int CNT_W       = cnt_width(UNLOCK_READS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] hidden_q
);

  acc_e             acc;
  logic [CNT_W-1:0] cnt_q;
  logic             armed;

  hdac_decode u_decode (
    .rd_en (rd_en),
    .wr_en (wr_en),
    .acc   (acc)
  );

  hdac_unlock_cnt #(
    .UNLOCK_READS (UNLOCK_READS)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc),
    .cnt_q (cnt_q),
    .armed (armed)
  );

  hdac_hidden_reg #(
    .DATA_W    (DATA_W),
    .RESET_VAL ('0)
  ) u_hidden (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .armed   (armed),
    .wdata   (wdata),
    .value_q (hidden_q)
  );

  hdac_rd_path #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .armed   (armed),
    .hidden  (hidden_q),
    .rdata_q (rdata)
  );

endmodule

// File: rtl/hdac_unlock_chk.sv
module hdac_unlock_chk #(
  parameter int DATA_W       = 8,
  parameter int UNLOCK_READS = 4,
  parameter int CNT_W        = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] hidden,
  input logic [CNT_W-1:0]  cnt,
  input logic              armed
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_READS);

  // R1: after reset the count starts from zero
  assert_reset_count_R1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && rdata == '1 && hidden == '0));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_locked_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !armed) |=> (rdata == '1 && cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_unlock_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && armed) |=> (rdata == $past(hidden) && cnt == '0));

  assert_armed_store_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && armed) |=> (hidden == $past(wdata)));

  assert_blocked_store_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && armed) |=> $stable(hidden));

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt == '0));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !wr_en) |=> $stable(rdata));

endmodule

bind hdac_unlock_seq hdac_unlock_chk #(
  .DATA_W       (DATA_W),
  .UNLOCK_READS (UNLOCK_READS),
  .CNT_W        (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rd_en  (rd_en),
  .wr_en  (wr_en),
  .wdata  (wdata),
  .rdata  (rdata),
  .hidden (hidden_q),
  .cnt    (cnt_q),
  .armed  (armed)
);

// File: tb/test_hdac_unlock_seq.sv
module test_hdac_unlock_seq;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [DW-1:0] hidden_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hdac_unlock_seq #(.DATA_W(DW), .UNLOCK_READS(4)) i_hdac_unlock_seq (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .hidden_q (hidden_q)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one read strobe; result sampled on the next falling edge
  task automatic do_read(output logic [DW-1:0] d);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk) begin wr_en = 1'b1; wdata = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic locked_reads(input int n, input string req);
    logic [DW-1:0] d;
    for (int i = 0; i < n; i++) begin
      do_read(d);
      check(req, d, 8'hFF);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata", rdata, 8'hFF);
    check("R1 hidden", hidden_q, 8'h00);
    // zero count: a write right away must not store
    do_write(8'hE1);
    check("R1 count zero", hidden_q, 8'h00);
  endtask

  task automatic t_unlock_wrap();
    logic [DW-1:0] d;
    locked_reads(4, "R2");
    do_read(d);
    check("R3 first unlock", d, 8'h00);
    // idle gap between reads must not matter
    @(negedge clk); @(negedge clk);
    locked_reads(4, "R2 after wrap");
    do_read(d);
    check("R3 second unlock", d, 8'h00);
  endtask

  task automatic t_store();
    logic [DW-1:0] d;
    locked_reads(4, "R2");
    do_write(8'h5A);
    check("R4 store", hidden_q, 8'h5A);
    locked_reads(4, "R6 after store");
    do_read(d);
    check("R3 returns stored", d, 8'h5A);
  endtask

  task automatic t_blocked();
    logic [DW-1:0] d;
    locked_reads(3, "R2");
    do_write(8'hC3);
    check("R5 three reads", hidden_q, 8'h5A);
    locked_reads(4, "R2");
    do_read(d);
    check("R3 unlock", d, 8'h5A);
    do_write(8'h11);
    check("R5 after unlock read", hidden_q, 8'h5A);
  endtask

  task automatic t_clear();
    locked_reads(2, "R2");
    do_write(8'h77);
    check("R5 two reads", hidden_q, 8'h5A);
    locked_reads(2, "R6");
    do_write(8'h88);
    check("R6 count cleared by write", hidden_q, 8'h5A);
    locked_reads(4, "R2");
    do_write(8'h99);
    check("R6 fresh arm stores", hidden_q, 8'h99);
  endtask

  task automatic t_hold();
    logic [DW-1:0] d;
    locked_reads(4, "R2");
    do_read(d);
    check("R3 unlock", d, 8'h99);
    repeat (3) @(negedge clk);
    check("R7 idle hold", rdata, 8'h99);
    do_write(8'h42);
    check("R7 write hold", rdata, 8'h99);
    check("R5 unarmed write", hidden_q, 8'h99);
  endtask

  initial begin
    t_reset();
    t_unlock_wrap();
    t_store();
    t_blocked();
    t_clear();
    t_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule